// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

The block takes two reference clocks and a feedback clock and samples all three with a faster system clock. It decides which reference feeds a downstream PLL. Each reference is checked over every feedback period. If a reference holds one level for a whole feedback period, measured between consecutive feedback rising edges, that reference is marked bad. The mark is latched and held until an alarm reset clears it.

The choice of reference normally follows a primary-select input. When manual override is low, the first reference to fail moves the choice to the other reference. That choice is held until an alarm reset. If both references are bad, the choice falls back to reference 0. The alarm reset is edge-triggered: a falling edge on its control pin makes one single-cycle pulse. After every change of choice, the block waits for a falling edge of the newly chosen reference. It then waits for the next rising edge of the feedback clock and the next rising edge of that reference. When both have arrived, it raises a one-cycle alignment request for the PLL.

The primary-select, override and alarm inputs are synchronous to the system clock. The three clock inputs may be asynchronous to it.

Top module: `refclk_failover`

## Requirements
- R1: Each clock input passes through a two-flop synchroniser. Monitoring starts at the first feedback rising edge after reset. At every later feedback rising edge, a reference is judged failed if its synchronised samples since the previous feedback rising edge do not include both a 1 and a 0. Those samples include the sample taken at the current edge.
- R2: A bad flag (`bad0_o` for reference 0, `bad1_o` for reference 1) rises in the cycle after its reference is judged failed. It stays high until an alarm reset, whatever reference is selected and whatever the override setting.
- R3: `sel_stat_o` is 0 when reference 0 is selected and 1 when reference 1 is selected. `sel_in` uses the same encoding to name the primary reference.
- R4: A 1-to-0 transition of `alarm_n_in` makes exactly one alarm pulse. Holding `alarm_n_in` low afterwards has no further effect, so a failure detected while it is held low still latches.
- R5: An alarm pulse clears both bad flags and loads `sel_stat_o` from `sel_in` at the next edge. If a failure is detected in the same cycle as the pulse, the pulse wins.
- R6: With `override_in` high, `sel_stat_o` takes the value of `sel_in` at every edge. Failure detection and bad-flag latching continue to run.
- R7: With `override_in` low and exactly one bad flag set, the other reference is selected. Changes on `sel_in` are ignored until an alarm reset.
- R8: With `override_in` low and no bad flag set, `sel_stat_o` follows `sel_in` one cycle later.
- R9: With `override_in` low and both bad flags set, `sel_stat_o` is 0.
- R10: After every change of `sel_stat_o`, the block waits for the first synchronised falling edge of the newly selected reference. After that edge it waits until it has seen both a feedback rising edge and a rising edge of that reference, in either order or in the same cycle. `align_req_o` is then high for one cycle. A new change of selection restarts this sequence.
- R11: While `rst` is high, both bad flags and `align_req_o` are 0 and `sel_stat_o` is loaded from `sel_in`. The alarm edge detector comes out of reset as if `alarm_n_in` had been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref0_in | input | 1 | Reference clock 0 (asynchronous) |
| ref1_in | input | 1 | Reference clock 1 (asynchronous) |
| fb_in | input | 1 | Feedback clock (asynchronous) |
| sel_in | input | 1 | Primary reference select: 0 names reference 0, 1 names reference 1 |
| override_in | input | 1 | High disables automatic failover |
| alarm_n_in | input | 1 | Alarm reset, acts on its falling edge |
| bad0_o | output | 1 | Latched failure flag for reference 0 |
| bad1_o | output | 1 | Latched failure flag for reference 1 |
| sel_stat_o | output | 1 | Selected reference (0 or 1) |
| align_req_o | output | 1 | One-cycle alignment request after a switch |

## Verification
The references run at two different periods against a slower feedback clock, so a healthy window always sees both levels. Each reference is also stuck low or stuck high in turn, which tells a genuine loss of toggling apart from a window that merely starts on a different level. The stuck-input runs are repeated with override high and with override low, and with both references dead. This separates failover from plain select following, and shows the fallback to reference 0 after an alarm reset while both inputs are still dead. Holding the alarm pin low while a new failure arrives shows that the alarm reset is edge-triggered rather than level-sensitive. Select toggles with healthy clocks exercise the alignment request sequence.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

  localparam int NUM_REFS = 2;

  typedef enum logic [1:0] {
    AL_IDLE      = 2'd0,
    AL_WAIT_FALL = 2'd1,
    AL_WAIT_PAIR = 2'd2
  } align_state_e;

  // True when a window closing on this sample never showed both levels.
  function automatic logic window_failed(input logic saw_one, input logic saw_zero,
                                         input logic sample);
    return !((saw_one | sample) & (saw_zero | ~sample));
  endfunction

  // Source choice from the flag vector, primary select and override.
  function automatic logic pick_source(input logic [NUM_REFS-1:0] bad,
                                       input logic primary, input logic manual);
    if (manual || bad == '0) return primary;
    if (&bad) return 1'b0;
    return bad[0];
  endfunction

endpackage

// File: rtl/refclk_sync.sv
module refclk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      prv <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prv <= chain[STAGES-1];
    end
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/refclk_activity_mon.sv
module refclk_activity_mon
  import refclk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic fb_rise,
  output logic fail
);
  logic saw_one, saw_zero, armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      saw_one  <= 1'b0;
      saw_zero <= 1'b0;
      armed    <= 1'b0;
    end else if (fb_rise) begin
      saw_one  <= 1'b0;
      saw_zero <= 1'b0;
      armed    <= 1'b1;
    end else begin
      saw_one  <= saw_one | lvl;
      saw_zero <= saw_zero | ~lvl;
    end
  end

  assign fail = fb_rise & armed & window_failed(saw_one, saw_zero, lvl);
endmodule

// File: rtl/refclk_select_ctrl.sv
module refclk_select_ctrl
  import refclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                alarm_n,
  input  logic                sel_in,
  input  logic                override,
  input  logic [NUM_REFS-1:0] fail_vec,
  output logic [NUM_REFS-1:0] bad_q,
  output logic                sel_q,
  output logic                alarm_pulse,
  output logic                switch_evt
);
  logic                alarm_q;
  logic [NUM_REFS-1:0] bad_nx;
  logic                sel_nx;

  assign alarm_pulse = alarm_q & ~alarm_n;

  always_comb begin
    if (alarm_pulse) begin
      bad_nx = '0;
      sel_nx = sel_in;
    end else begin
      bad_nx = bad_q | fail_vec;
      sel_nx = pick_source(bad_nx, sel_in, override);
    end
  end

  assign switch_evt = (sel_nx != sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_q   <= '0;
      sel_q   <= sel_in;
      alarm_q <= 1'b1;
    end else begin
      bad_q   <= bad_nx;
      sel_q   <= sel_nx;
      alarm_q <= alarm_n;
    end
  end
endmodule

// File: rtl/refclk_align_track.sv
module refclk_align_track
  import refclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                switch_evt,
  input  logic                sel_q,
  input  logic [NUM_REFS-1:0] ref_lvl,
  input  logic [NUM_REFS-1:0] ref_prv,
  input  logic                fb_rise,
  output logic                align_req
);
  align_state_e state;
  logic got_fb, got_ref;
  logic cur_rise, cur_fall, fb_ok, ref_ok;

  assign cur_rise = ref_lvl[sel_q] & ~ref_prv[sel_q];
  assign cur_fall = ~ref_lvl[sel_q] & ref_prv[sel_q];
  assign fb_ok    = got_fb | fb_rise;
  assign ref_ok   = got_ref | cur_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= AL_IDLE;
      got_fb    <= 1'b0;
      got_ref   <= 1'b0;
      align_req <= 1'b0;
    end else begin
      align_req <= 1'b0;
      if (switch_evt) begin
        state   <= AL_WAIT_FALL;
        got_fb  <= 1'b0;
        got_ref <= 1'b0;
      end else begin
        case (state)
          AL_WAIT_FALL: if (cur_fall) begin
            state   <= AL_WAIT_PAIR;
            got_fb  <= 1'b0;
            got_ref <= 1'b0;
          end
          AL_WAIT_PAIR: begin
            if (fb_ok && ref_ok) begin
              align_req <= 1'b1;
              state     <= AL_IDLE;
              got_fb    <= 1'b0;
              got_ref   <= 1'b0;
            end else begin
              got_fb  <= fb_ok;
              got_ref <= ref_ok;
            end
          end
          default: state <= AL_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
  import refclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref0_in,
  input  logic ref1_in,
  input  logic fb_in,
  input  logic sel_in,
  input  logic override_in,
  input  logic alarm_n_in,
  output logic bad0_o,
  output logic bad1_o,
  output logic sel_stat_o,
  output logic align_req_o
);
  logic [NUM_REFS-1:0] ref_lvl, ref_prv, fail_vec, bad_vec;
  logic fb_lvl, fb_prv, fb_rise;
  logic alarm_pulse, switch_evt, sel_q;

  refclk_sync #(.W(NUM_REFS), .STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk), .rst(rst), .d({ref1_in, ref0_in}), .lvl(ref_lvl), .prv(ref_prv));

  refclk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_fb_sync (
    .clk(clk), .rst(rst), .d(fb_in), .lvl(fb_lvl), .prv(fb_prv));

  assign fb_rise = fb_lvl & ~fb_prv;

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_mon
    refclk_activity_mon u_mon (
      .clk(clk), .rst(rst), .lvl(ref_lvl[g]), .fb_rise(fb_rise), .fail(fail_vec[g]));
  end

  refclk_select_ctrl u_ctrl (
    .clk(clk), .rst(rst), .alarm_n(alarm_n_in), .sel_in(sel_in),
    .override(override_in), .fail_vec(fail_vec), .bad_q(bad_vec), .sel_q(sel_q),
    .alarm_pulse(alarm_pulse), .switch_evt(switch_evt));

  refclk_align_track u_align (
    .clk(clk), .rst(rst), .switch_evt(switch_evt), .sel_q(sel_q),
    .ref_lvl(ref_lvl), .ref_prv(ref_prv), .fb_rise(fb_rise), .align_req(align_req_o));

  assign bad0_o     = bad_vec[0];
  assign bad1_o     = bad_vec[1];
  assign sel_stat_o = sel_q;
endmodule

// File: rtl/refclk_failover_chk.sv
module refclk_failover_chk (
  input logic       clk,
  input logic       rst,
  input logic       alarm_pulse,
  input logic       switch_evt,
  input logic [1:0] fail_vec,
  input logic       bad0_o,
  input logic       bad1_o,
  input logic       sel_stat_o,
  input logic       sel_in,
  input logic       override_in,
  input logic       align_req_o
);
  a_r4_alarm_single: assert property (@(posedge clk) disable iff (rst)
    alarm_pulse |=> !alarm_pulse);

  a_r2_bad0_sticky: assert property (@(posedge clk) disable iff (rst)
    (bad0_o && !alarm_pulse) |=> bad0_o);

  a_r2_bad1_sticky: assert property (@(posedge clk) disable iff (rst)
    (bad1_o && !alarm_pulse) |=> bad1_o);

  a_r1_fail_latches: assert property (@(posedge clk) disable iff (rst)
    (fail_vec[0] && !alarm_pulse) |=> bad0_o);

  a_r5_alarm_clears: assert property (@(posedge clk) disable iff (rst)
    alarm_pulse |=> (!bad0_o && !bad1_o && sel_stat_o == $past(sel_in)));

  a_r6_override_follow: assert property (@(posedge clk) disable iff (rst)
    override_in |=> (sel_stat_o == $past(sel_in)));

  a_r8_clean_follow: assert property (@(posedge clk) disable iff (rst)
    (!override_in && fail_vec == 2'b00 && !bad0_o && !bad1_o) |=>
      (sel_stat_o == $past(sel_in)));

  a_r9_both_bad_zero: assert property (@(posedge clk) disable iff (rst)
    (bad0_o && bad1_o && !override_in && !alarm_pulse) |=> !sel_stat_o);

  a_r10_align_single: assert property (@(posedge clk) disable iff (rst)
    align_req_o |=> !align_req_o);

  a_r10_switch_restarts: assert property (@(posedge clk) disable iff (rst)
    switch_evt |=> !align_req_o);
endmodule

bind refclk_failover refclk_failover_chk u_chk (
  .clk(clk), .rst(rst), .alarm_pulse(alarm_pulse), .switch_evt(switch_evt),
  .fail_vec(fail_vec), .bad0_o(bad0_o), .bad1_o(bad1_o), .sel_stat_o(sel_stat_o),
  .sel_in(sel_in), .override_in(override_in), .align_req_o(align_req_o));

// File: tb/tb_refclk_failover.sv
`timescale 1ns/1ps
module tb_refclk_failover;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref0_in = 0, ref1_in = 0, fb_in = 0;
  logic sel_in = 0, override_in = 0, alarm_n_in = 1;
  logic bad0_o, bad1_o, sel_stat_o, align_req_o;

  always #2.5 clk = ~clk;

  refclk_failover dut (
    .clk(clk), .rst(rst), .ref0_in(ref0_in), .ref1_in(ref1_in), .fb_in(fb_in),
    .sel_in(sel_in), .override_in(override_in), .alarm_n_in(alarm_n_in),
    .bad0_o(bad0_o), .bad1_o(bad1_o), .sel_stat_o(sel_stat_o), .align_req_o(align_req_o));

  int checks = 0, fails = 0, cyc = 0, align_seen = 0;
  string cur_req = "R11";
  bit started = 0, run0 = 1, run1 = 1, stuck0 = 0, stuck1 = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Stimulus clocks: ref0 period 8, ref1 period 6, feedback period 10.
  always @(negedge clk) begin
    cyc++;
    ref0_in <= run0 ? ((cyc / 4) % 2 == 1) : stuck0;
    ref1_in <= run1 ? ((cyc / 3) % 2 == 1) : stuck1;
    fb_in   <= ((cyc / 5) % 2 == 1);
  end

  // Reference model: sample history, per-window level counts, behavioural state.
  bit h0 [$], h1 [$], hf [$];
  int hi0, lo0, hi1, lo1, aph;
  bit m_armed, m_bad0, m_bad1, m_sel, m_align, m_alq, gf, gr;

  always @(posedge clk) begin
    if (rst) begin
      h0 = '{0,0,0}; h1 = '{0,0,0}; hf = '{0,0,0};
      hi0 = 0; lo0 = 0; hi1 = 0; lo1 = 0; aph = 0;
      m_armed = 0; m_bad0 = 0; m_bad1 = 0; m_sel = sel_in; m_align = 0; m_alq = 1;
      gf = 0; gr = 0;
    end else begin
      bit l0, l1, lf, r0, r1, f0, f1, fr, f_0, f_1, pulse, nb0, nb1, ns, na, rr, rf;
      l0 = h0[1]; l1 = h1[1]; lf = hf[1];
      r0 = l0 && !h0[2]; r1 = l1 && !h1[2]; f0 = !l0 && h0[2]; f1 = !l1 && h1[2];
      fr = lf && !hf[2];
      f_0 = fr && m_armed && ((hi0 + l0 == 0) || (lo0 + !l0 == 0));
      f_1 = fr && m_armed && ((hi1 + l1 == 0) || (lo1 + !l1 == 0));
      if (fr) begin hi0 = 0; lo0 = 0; hi1 = 0; lo1 = 0; m_armed = 1; end
      else begin hi0 += l0; lo0 += !l0; hi1 += l1; lo1 += !l1; end
      pulse = m_alq && !alarm_n_in;
      m_alq = alarm_n_in;
      if (pulse) begin nb0 = 0; nb1 = 0; ns = sel_in; end
      else begin
        nb0 = m_bad0 || f_0; nb1 = m_bad1 || f_1;
        if (override_in || (!nb0 && !nb1)) ns = sel_in;
        else if (nb0 && nb1) ns = 0;
        else ns = nb0;
      end
      rr = m_sel ? r1 : r0; rf = m_sel ? f1 : f0;
      na = 0;
      if (ns != m_sel) begin aph = 1; gf = 0; gr = 0; end
      else if (aph == 1) begin if (rf) begin aph = 2; gf = 0; gr = 0; end end
      else if (aph == 2) begin
        gf = gf || fr; gr = gr || rr;
        if (gf && gr) begin na = 1; aph = 0; gf = 0; gr = 0; end
      end
      m_bad0 = nb0; m_bad1 = nb1; m_sel = ns; m_align = na;
      h0.push_front(ref0_in); h1.push_front(ref1_in); hf.push_front(fb_in);
      void'(h0.pop_back()); void'(h1.pop_back()); void'(hf.pop_back());
      started = 1;
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) if (started) begin
    chk({cur_req, " bad0"}, bad0_o, m_bad0);
    chk({cur_req, " bad1"}, bad1_o, m_bad1);
    chk({cur_req, " sel"}, sel_stat_o, m_sel);
    chk({cur_req, " align"}, align_req_o, m_align);
    if (align_req_o) align_seen++;
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic alarm_edge(int hold);
    alarm_n_in = 0; wait_n(hold); alarm_n_in = 1;
  endtask

  initial begin
    wait_n(5);
    cur_req = "R11";
    chk("R11 reset bad0", bad0_o, 0); chk("R11 reset bad1", bad1_o, 0);
    chk("R11 reset sel", sel_stat_o, 0); chk("R11 reset align", align_req_o, 0);
    rst = 0;
    // R8 / R3 / R10: healthy clocks, select toggles.
    cur_req = "R8_R10";
    wait_n(30);
    sel_in = 1; wait_n(2);
    chk("R3 sel follows to 1", sel_stat_o, 1);
    wait_n(30);
    sel_in = 0; wait_n(30);
    chk("R10 alignment pulses seen", int'(align_seen >= 2), 1);
    // R1 / R7: reference 0 stuck low, failover to reference 1.
    cur_req = "R1_R7";
    run0 = 0; stuck0 = 0; wait_n(40);
    chk("R1 bad0 latched", bad0_o, 1);
    chk("R7 failover to 1", sel_stat_o, 1);
    run0 = 1; sel_in = 1; wait_n(3); sel_in = 0; wait_n(30);
    chk("R2 bad0 still latched", bad0_o, 1);
    chk("R7 sel_in ignored", sel_stat_o, 1);
    // R4 / R5: alarm held low while reference 0 fails again.
    cur_req = "R4_R5";
    alarm_n_in = 0; wait_n(1);
    chk("R5 alarm cleared bad0", bad0_o, 0);
    chk("R5 alarm loads sel", sel_stat_o, 0);
    run0 = 0; stuck0 = 1; wait_n(40);
    chk("R4 held alarm has no effect", bad0_o, 1);
    alarm_n_in = 1; run0 = 1; wait_n(3);
    alarm_edge(2); wait_n(20);
    chk("R5 flags clear after second alarm", bad0_o, 0);
    // R6: override high, reference 1 stuck high.
    cur_req = "R6";
    override_in = 1; run1 = 0; stuck1 = 1; wait_n(40);
    chk("R6 bad1 latched under override", bad1_o, 1);
    chk("R6 sel stays at sel_in", sel_stat_o, 0);
    sel_in = 1; wait_n(2);
    chk("R6 sel follows under override", sel_stat_o, 1);
    // R9: both references dead, override low.
    cur_req = "R9";
    override_in = 0; run0 = 0; stuck0 = 0; wait_n(40);
    chk("R9 both bad", bad0_o & bad1_o, 1);
    chk("R9 sel falls back to 0", sel_stat_o, 0);
    alarm_edge(1);
    chk("R5 alarm with both dead", {bad1_o, bad0_o, sel_stat_o}, 3'b001);
    wait_n(30);
    chk("R9 relatch both after alarm", {bad1_o, bad0_o, sel_stat_o}, 3'b110);
    // R11: reset during activity.
    cur_req = "R11";
    rst = 1; started = 0; wait_n(3);
    chk("R11 reset mid-run flags", bad0_o | bad1_o, 0);
    chk("R11 reset mid-run sel", sel_stat_o, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_n(20000);
    fails++; checks++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule